// File: doc/BRIEF.md
# Key-Locked DRAM Controller Register Bank

This block holds the 32-bit control and status words of a DRAM controller. The words sit in a 4 KB address window and are reached over a simple single-cycle bus that carries an address, write data, a byte strobe and a write flag, and returns read data. A protection word at offset 0x00 sets whether writes reach the rest of the bank. Writing the unlock key opens the bank. Writing the hard-lock key freezes every protected word, the protection word included, until the next reset. Writing any other value returns the bank to the soft-locked state, in which only the protection word can still be written.

A fixed set of words accepts writes in every lock state. The configuration word carries a hardware version, an aperture code and a DRAM-size code, and software cannot alter any of them. The size code comes from the `DRAM_MB` parameter. On a write, the PHY status word and the ECC self-test word have some bits forced, so software always reads back an idle, locked PLL and a finished, passing test. A one-cycle `lock_err` pulse reports each write that the lock state drops.

Top module: `dram_regbank`

## Requirements
- R1: A write of 0xFC600309 to offset 0x00 stores 0x01 (unlocked). A write of 0xDEADDEAD stores 0x10 (hard-locked). A write of any other value stores 0x00 (soft-locked).
- R2: While the protection word reads 0x10, every write to a protected word is dropped until reset, including writes to offset 0x00.
- R3: While the protection word reads 0x00, writes to protected words other than offset 0x00 are dropped. A write to offset 0x00 is still decoded per R1.
- R4: Offsets 0x50, 0x6C, 0x74, 0x78, 0x7C, 0x88, 0x8C and 0xB4 take the written value unchanged in every lock state.
- R5: The configuration word at 0x04 always reads 0x3 in bits 31:28 and 0b11 in bits 3:2. Bits 19, 18:14 and 6 read 0 after any write. Bits 27:20, 13:7 and 5:4 keep the written value.
- R6: Bits 1:0 of the configuration word hold the size code for `DRAM_MB` (256→0, 512→1, 1024→2, 2048→3) and never change. Elaboration fails for any other size.
- R7: A write to offset 0x60 stores the data with bit 0 cleared and bit 4 set.
- R8: A write to offset 0x70 stores the data with bit 12 set and bit 13 cleared.
- R9: After reset the bank is soft-locked, all words read 0 except these: configuration 0x3000000C | size code, offset 0x400 = 0x2, offsets 0x468 and 0x47C = 0xFF, offset 0x450 = 0x0FFFFFFF.
- R10: A write with a strobe other than 4'hF is ignored. A read at a word index at or beyond `NUM_WORDS` returns 0, and a write there is ignored.
- R11: `lock_err` is high for exactly the one cycle after a full, in-range write that the lock state drops, and low otherwise.
- R12: While unlocked, a write to an ordinary protected word such as offset 0x10 stores the data unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 12 | Byte address within the 4 KB window |
| req_wdata | input | 32 | Write data |
| req_strb | input | 4 | Byte strobe; only 4'hF writes |
| rd_data | output | 32 | Word at `req_addr`, combinational |
| lock_err | output | 1 | One-cycle pulse for a write dropped by the lock |

## Verification
A write is captured at the rising edge that sees it, so the stored word shows on `rd_data` right after that edge. `lock_err` rises at the same edge and falls at the next one. Read data is a combinational function of the address. The bench drives every request on a falling edge and samples `lock_err` and the written result at the next falling edge, which is half a cycle after the capturing edge. It then samples once more a full cycle later to confirm that the pulse has ended. Reads are sampled one time unit after the address changes, with no clock edge in between, so a read never mixes with a write that is still in flight.

// File: rtl/dram_regbank.sv
module dram_regbank #(
  parameter int DRAM_MB   = 1024,
  parameter int NUM_WORDS = 512
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic        req_write,
  input  logic [11:0] req_addr,
  input  logic [31:0] req_wdata,
  input  logic [3:0]  req_strb,
  output logic [31:0] rd_data,
  output logic        lock_err
);
  localparam int IW = $clog2(NUM_WORDS);
  localparam int SIZE_IDX = (DRAM_MB == 256)  ? 0 :
                            (DRAM_MB == 512)  ? 1 :
                            (DRAM_MB == 1024) ? 2 :
                            (DRAM_MB == 2048) ? 3 : -1;

  if (SIZE_IDX < 0) begin : g_bad_size
    $error("dram_regbank: DRAM_MB must be 256, 512, 1024 or 2048");
  end
  if (NUM_WORDS < 'h120 || NUM_WORDS > 1024) begin : g_bad_depth
    $error("dram_regbank: NUM_WORDS must lie in 288..1024");
  end

  localparam logic [9:0] W_PROT = 10'h000;
  localparam logic [9:0] W_CFG  = 10'h001;
  localparam logic [9:0] W_STAT = 10'h018;
  localparam logic [9:0] W_ECCT = 10'h01C;

  localparam logic [31:0] KEY_OPEN = 32'hFC60_0309;
  localparam logic [31:0] KEY_HARD = 32'hDEAD_DEAD;
  localparam logic [31:0] ST_OPEN  = 32'h0000_0001;
  localparam logic [31:0] ST_HARD  = 32'h0000_0010;
  localparam logic [31:0] ST_SOFT  = 32'h0000_0000;

  localparam logic [31:0] CFG_RO  = 32'hF00F_C04F;
  localparam logic [31:0] CFG_FIX = 32'h3000_000C | 32'(SIZE_IDX & 3);

  function automatic logic always_open(input logic [9:0] w);
    case (w)
      10'h014, 10'h01B, 10'h01D, 10'h01E,
      10'h01F, 10'h022, 10'h023, 10'h02D: return 1'b1;
      default:                            return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] reset_word(input int i);
    case (i)
      int'(W_CFG): return CFG_FIX;
      'h100:       return 32'h0000_0002;
      'h11A:       return 32'h0000_00FF;
      'h11F:       return 32'h0000_00FF;
      'h114:       return 32'h0FFF_FFFF;
      default:     return 32'h0;
    endcase
  endfunction

  logic [31:0] mem [NUM_WORDS];
  logic [9:0]  word;
  logic        in_range, wr_full, gate_open, wr_take, wr_drop;
  logic [31:0] prot, shaped;

  assign word     = req_addr[11:2];
  assign in_range = int'(word) < NUM_WORDS;
  assign prot     = mem[W_PROT[IW-1:0]];
  assign rd_data  = in_range ? mem[word[IW-1:0]] : 32'h0;

  assign wr_full   = req_valid && req_write && req_strb == 4'hF && in_range;
  assign gate_open = always_open(word) || prot == ST_OPEN ||
                     (prot == ST_SOFT && word == W_PROT);
  assign wr_take   = wr_full && gate_open;
  assign wr_drop   = wr_full && !gate_open;

  always_comb begin
    shaped = req_wdata;
    case (word)
      W_PROT:  shaped = (req_wdata == KEY_OPEN) ? ST_OPEN :
                        (req_wdata == KEY_HARD) ? ST_HARD : ST_SOFT;
      W_CFG:   shaped = (req_wdata & ~CFG_RO) | CFG_FIX;
      W_STAT:  shaped = (req_wdata & ~32'h1) | 32'h10;
      W_ECCT:  shaped = (req_wdata & ~32'h2000) | 32'h1000;
      default: shaped = req_wdata;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_WORDS; i++) mem[i] <= reset_word(i);
      lock_err <= 1'b0;
    end else begin
      if (wr_take) mem[word[IW-1:0]] <= shaped;
      lock_err <= wr_drop;
    end
  end

  // R1
  prot_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot == ST_OPEN || prot == ST_SOFT || prot == ST_HARD);

  // R2
  hard_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot == ST_HARD |=> prot == ST_HARD);

  // R2
  hard_freeze_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot == ST_HARD |=> $stable(mem[W_CFG[IW-1:0]]));

  // R5
  cfg_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem[W_CFG[IW-1:0]][31:28] == 4'h3 && mem[W_CFG[IW-1:0]][19:14] == 6'h0 &&
    mem[W_CFG[IW-1:0]][6] == 1'b0 && mem[W_CFG[IW-1:0]][3:2] == 2'b11);

  // R6
  cfg_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(mem[W_CFG[IW-1:0]][1:0]) == SIZE_IDX);

  // R7
  stat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem[W_STAT[IW-1:0]][0] == 1'b0);

  // R8
  ecc_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem[W_ECCT[IW-1:0]][13] == 1'b0);

  // R11
  err_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_err |-> prot != ST_OPEN);

  // R11
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock_err |=> !lock_err || $past(wr_drop));
endmodule

// File: tb/dram_regbank_test.sv
module dram_regbank_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_strb = '0;
  logic [31:0] rd_data;
  logic        lock_err;

  int runs = 0;
  int fails = 0;
  bit done = 0;
  bit got_err;

  localparam logic [31:0] K_OPEN = 32'hFC60_0309;
  localparam logic [31:0] K_HARD = 32'hDEAD_DEAD;

  always #4 clk = ~clk;

  dram_regbank uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
    .rd_data(rd_data), .lock_err(lock_err)
  );

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    runs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", tag, got, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d, input logic [3:0] s = 4'hF);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d; req_strb = s;
    @(negedge clk);
    got_err = lock_err;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    req_addr = a;
    #1;
    d = rd_data;
  endtask

  task automatic expect_word(input string tag, input logic [11:0] a, input logic [31:0] e);
    logic [31:0] v;
    rd(a, v);
    check(tag, v, e);
  endtask

  task automatic t_reset();
    do_reset();
    check("R11 lock_err after reset", {31'b0, lock_err}, 32'h0);
    expect_word("R9 prot soft after reset", 12'h000, 32'h0);
    expect_word("R9 R6 cfg after reset", 12'h004, 32'h3000_000E);
    expect_word("R9 word 0x400", 12'h400, 32'h2);
    expect_word("R9 word 0x468", 12'h468, 32'hFF);
    expect_word("R9 word 0x47C", 12'h47C, 32'hFF);
    expect_word("R9 word 0x450", 12'h450, 32'h0FFF_FFFF);
    expect_word("R9 word 0x10", 12'h010, 32'h0);
    expect_word("R9 word 0x60", 12'h060, 32'h0);
  endtask

  task automatic t_soft();
    wr(12'h010, 32'hA5A5_0001);
    check("R11 pulse on soft drop", {31'b0, got_err}, 32'h1);
    expect_word("R3 soft drop word 0x10", 12'h010, 32'h0);
    @(negedge clk);
    check("R11 pulse ends", {31'b0, lock_err}, 32'h0);
    wr(12'h004, 32'hFFFF_FFFF);
    check("R3 cfg drop flagged", {31'b0, got_err}, 32'h1);
    expect_word("R3 cfg unchanged in soft", 12'h004, 32'h3000_000E);
  endtask

  task automatic t_whitelist(input string st);
    logic [11:0] offs [8] = '{12'h050, 12'h06C, 12'h074, 12'h078,
                             12'h07C, 12'h088, 12'h08C, 12'h0B4};
    for (int i = 0; i < 8; i++) begin
      logic [31:0] d;
      d = 32'h1357_0000 + 32'(i) + (st == "hard" ? 32'h100 : 32'h0);
      wr(offs[i], d);
      check({"R4 no error ", st}, {31'b0, got_err}, 32'h0);
      expect_word({"R4 open word ", st}, offs[i], d);
    end
  endtask

  task automatic t_unlock();
    wr(12'h000, K_OPEN);
    check("R1 unlock no error", {31'b0, got_err}, 32'h0);
    expect_word("R1 unlock stores 1", 12'h000, 32'h1);
    wr(12'h010, 32'hCAFE_F00D);
    expect_word("R12 plain word stored", 12'h010, 32'hCAFE_F00D);
    check("R11 no pulse when open", {31'b0, got_err}, 32'h0);
  endtask

  task automatic t_cfg();
    wr(12'h004, 32'hFFFF_FFFF);
    expect_word("R5 R6 cfg all ones", 12'h004, 32'h3FF0_3FBE);
    wr(12'h004, 32'h0000_0000);
    expect_word("R5 R6 cfg all zeros", 12'h004, 32'h3000_000E);
    wr(12'h004, 32'h0550_2A21);
    expect_word("R5 R6 cfg mixed", 12'h004, 32'h3550_2A2E);
  endtask

  task automatic t_forced();
    wr(12'h060, 32'h0000_0001);
    expect_word("R7 status busy cleared", 12'h060, 32'h0000_0010);
    wr(12'h060, 32'hFFFF_FFFF);
    expect_word("R7 status all ones", 12'h060, 32'hFFFF_FFFE);
    wr(12'h070, 32'h0000_2000);
    expect_word("R8 ecc fail cleared", 12'h070, 32'h0000_1000);
    wr(12'h070, 32'hFFFF_FFFF);
    expect_word("R8 ecc all ones", 12'h070, 32'hFFFF_DFFF);
  endtask

  task automatic t_access();
    wr(12'h010, 32'h1111_2222, 4'h3);
    expect_word("R10 partial strobe ignored", 12'h010, 32'hCAFE_F00D);
    wr(12'h800, 32'hDEAD_BEEF);
    check("R10 out of range no error", {31'b0, got_err}, 32'h0);
    expect_word("R10 out of range read 0x800", 12'h800, 32'h0);
    expect_word("R10 out of range read 0xFFC", 12'h FFC, 32'h0);
    expect_word("R10 low word intact", 12'h000, 32'h1);
  endtask

  task automatic t_relock();
    wr(12'h000, 32'h1234_5678);
    expect_word("R1 other value soft-locks", 12'h000, 32'h0);
    wr(12'h010, 32'h0BAD_0BAD);
    expect_word("R3 drop after relock", 12'h010, 32'hCAFE_F00D);
    wr(12'h000, K_OPEN);
    expect_word("R3 unlock from soft", 12'h000, 32'h1);
  endtask

  task automatic t_hard();
    wr(12'h000, K_HARD);
    expect_word("R1 hard key stores 0x10", 12'h000, 32'h10);
    wr(12'h000, K_OPEN);
    check("R2 prot write flagged", {31'b0, got_err}, 32'h1);
    expect_word("R2 unlock refused", 12'h000, 32'h10);
    wr(12'h010, 32'h7777_7777);
    expect_word("R2 word 0x10 frozen", 12'h010, 32'hCAFE_F00D);
    wr(12'h060, 32'h0);
    expect_word("R2 status frozen", 12'h060, 32'hFFFF_FFFE);
    t_whitelist("hard");
    do_reset();
    expect_word("R9 R2 reset clears hard lock", 12'h000, 32'h0);
    expect_word("R9 word 0x10 cleared", 12'h010, 32'h0);
  endtask

  initial begin
    t_reset();
    t_soft();
    t_whitelist("soft");
    t_unlock();
    t_cfg();
    t_forced();
    t_access();
    t_relock();
    t_hard();
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      runs++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end
endmodule